// File: doc/BRIEF.md
# GPIO Controller with Grouped Interrupt Banks

This block is a memory-mapped GPIO controller. Each pin owns one 32-bit configuration word. A single 3-bit mode field in that word sets the pin direction and the trigger type for its interrupt. The other fields of the word hold the output data bit, a peripheral function select, a pull setting, an input enable, the drive strength and Schmitt settings, a lock bit and a 3-bit interrupt group number. Only the direction, data, mode, group and lock fields act on the logic; the pad attributes are stored and read back.

Every pin input passes through a synchroniser and then a detector that runs in the pin's mode. When the detector fires, it sets the pin's pending flag. That flag is visible only in the status bank of the group the pin has selected. Each group has a bank of 32-bit status words. Writing 1 to a bit of a status word acknowledges that pin. Each group also drives its own interrupt line, which a parent interrupt controller receives.

A simple one-cycle read/write port gives access to the block. A read returns its data on the clock edge after the one that samples the request.

Top module: `gpio_grp_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0x0000000E (mode 7, all other fields 0, pin low), all group interrupt lines are 0 and no pin is driven.
- R2: Pin N's word is at byte offset 4*N. Writable bits are the mask 0x00E78FEF: data 0, mode 3:1, function 6:5, pull 8:7, input enable 9, drive 11:10 and 23:22, Schmitt 15, group 18:16, lock 21. All other bits read 0, and a word beyond the pin count reads 0.
- R3: In mode 1 (output), pin_oe is 1, pin_out follows the data bit, and the data bit reads back the written value.
- R4: In any mode other than 1, bit 0 of the word reads the synchronised pin level, valid no later than three clocks after the pin changes.
- R5: Mode 2 (level high) and mode 3 (level low) set pending while the level holds. A clear takes effect for one cycle, and pending sets again on the next cycle if the condition still holds. Pending stays set after the level goes away, until it is cleared.
- R6: Mode 4 (rising), mode 5 (falling) and mode 6 (either edge) set pending on the matching transition of the synchronised input. The flag stays set after the pin returns to its earlier level.
- R7: In mode 7 (input, interrupt off) and in mode 1, pin changes raise no new pending event.
- R8: The status word for group g and pins 32k..32k+31 is at byte offset 0x800 + 0x40*g + 4*k, with bit (pin mod 32) for the pin. A pending pin shows only in the bank of the group that field 18:16 selects, and reads 0 in all other banks.
- R9: Writing 1 to a status bit clears that pin's pending flag. Writing 0 has no effect. Writing 1 in a bank other than the pin's own group has no effect.
- R10: grp_irq[g] equals the OR of group g's pending bits, delayed by one register stage.
- R11: While the lock bit of a pin is 1, writes to its word change only the data bit.
- R12: Changing the mode of a pending pin keeps the pending flag until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, data on the next cycle |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data per pin |
| pin_oe | output | NPINS | Output enable per pin (mode 1) |
| grp_irq | output | NGRP | Per-group interrupt lines |

## Verification
The assertions take three things for granted. Reset lasts at least one clock. Addresses are word aligned. No detector event is expected to survive a clear issued in the same cycle, because the clear wins. The stimulus drives bus and pin signals only on falling clock edges. It holds each pin level for at least four clocks, so every edge passes the synchroniser and the detector. It never writes a clear while an edge is still in flight on the pin being cleared.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  typedef enum logic [2:0] {
    MD_NONE   = 3'd0,
    MD_OUT    = 3'd1,
    MD_LVL_HI = 3'd2,
    MD_LVL_LO = 3'd3,
    MD_RISE   = 3'd4,
    MD_FALL   = 3'd5,
    MD_BOTH   = 3'd6,
    MD_QUIET  = 3'd7
  } mode_e;

  localparam logic [31:0] CFG_KEEP_MASK = 32'h00E78FEF;
  localparam logic [31:0] CFG_RESET     = 32'h0000000E;
  localparam int          LOCK_BIT      = 21;
  localparam int          GRP_LSB       = 16;
  localparam int          MODE_LSB      = 1;
  localparam int          WORD_BITS     = 32;
endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta  <= '0;
      lvl   <= '0;
      lvl_d <= '0;
    end else begin
      meta  <= din;
      lvl   <= meta;
      lvl_d <= lvl;
    end
  end
endmodule

// File: rtl/gpc_detect.sv
module gpc_detect
  import gpc_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3*NPINS-1:0] mode_flat,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] lvl_d,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] pend
);
  logic [NPINS-1:0] fire;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    mode_e m;
    logic  s;
    assign m = mode_e'(mode_flat[3*i +: 3]);
    always_comb begin
      case (m)
        MD_LVL_HI: s = lvl[i];
        MD_LVL_LO: s = !lvl[i];
        MD_RISE:   s = lvl[i] && !lvl_d[i];
        MD_FALL:   s = !lvl[i] && lvl_d[i];
        MD_BOTH:   s = lvl[i] ^ lvl_d[i];
        default:   s = 1'b0;
      endcase
    end
    assign fire[i] = s;
  end

  // a clear wins over a new event in the same cycle
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | fire) & ~clr;
  end
endmodule

// File: rtl/gpc_groups.sv
module gpc_groups #(
  parameter int NPINS = 8,
  parameter int NGRP  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   pend,
  input  logic [3*NPINS-1:0] grp_flat,
  output logic [NGRP-1:0]    irq
);
  logic [NGRP-1:0] any_v;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic any;
    always_comb begin
      any = 1'b0;
      for (int p = 0; p < NPINS; p++)
        if (pend[p] && grp_flat[3*p +: 3] == 3'(g)) any = 1'b1;
    end
    assign any_v[g] = any;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= any_v;
  end
endmodule

// File: rtl/gpio_grp_ctrl.sv
module gpio_grp_ctrl
  import gpc_pkg::*;
#(
  parameter int NPINS  = 40,
  parameter int NGRP   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NGRP-1:0]   grp_irq
);
  localparam int NWORDS = (NPINS + WORD_BITS - 1) / WORD_BITS;
  localparam int IDX_W  = ADDR_W - 3;

  logic [31:0]        cfg [NPINS];
  logic [NPINS-1:0]   lvl, lvl_d, pend, clr, lock_v;
  logic [3*NPINS-1:0] mode_flat, grp_flat;
  logic [31:0]        rd_val;

  // address decode: bit ADDR_W-1 picks the status region
  logic [IDX_W-1:0] cfg_idx;
  logic [2:0]       stat_g;
  logic [3:0]       stat_k;
  logic             aligned, cfg_hit, stat_hit;

  assign cfg_idx  = bus_addr[ADDR_W-2:2];
  assign stat_g   = bus_addr[8:6];
  assign stat_k   = bus_addr[5:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign cfg_hit  = aligned && !bus_addr[ADDR_W-1] && (int'(cfg_idx) < NPINS);
  assign stat_hit = aligned && bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:9] == '0)
                    && (int'(stat_g) < NGRP) && (int'(stat_k) < NWORDS);

  for (genvar i = 0; i < NPINS; i++) begin : g_fld
    assign mode_flat[3*i +: 3] = cfg[i][MODE_LSB +: 3];
    assign grp_flat[3*i +: 3]  = cfg[i][GRP_LSB +: 3];
    assign lock_v[i]           = cfg[i][LOCK_BIT];
    assign pin_oe[i]           = (mode_e'(cfg[i][MODE_LSB +: 3]) == MD_OUT);
    assign pin_out[i]          = cfg[i][0];
  end

  // configuration words
  always_ff @(posedge clk) begin
    for (int i = 0; i < NPINS; i++) begin
      if (rst) begin
        cfg[i] <= CFG_RESET;
      end else if (bus_wr && cfg_hit && int'(cfg_idx) == i) begin
        if (cfg[i][LOCK_BIT]) cfg[i][0] <= bus_wdata[0];
        else                  cfg[i]    <= bus_wdata & CFG_KEEP_MASK;
      end
    end
  end

  // write-one-to-clear, only through the pin's own group bank
  always_comb begin
    for (int p = 0; p < NPINS; p++)
      clr[p] = bus_wr && stat_hit && (int'(stat_k) == p / WORD_BITS)
               && (cfg[p][GRP_LSB +: 3] == stat_g) && bus_wdata[p % WORD_BITS];
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (cfg_hit) begin
      for (int i = 0; i < NPINS; i++) begin
        if (int'(cfg_idx) == i) begin
          rd_val = cfg[i];
          if (mode_e'(cfg[i][MODE_LSB +: 3]) != MD_OUT) rd_val[0] = lvl[i];
        end
      end
    end else if (stat_hit) begin
      for (int p = 0; p < NPINS; p++)
        if (int'(stat_k) == p / WORD_BITS && cfg[p][GRP_LSB +: 3] == stat_g)
          rd_val[p % WORD_BITS] = pend[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  gpc_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .lvl(lvl), .lvl_d(lvl_d)
  );

  gpc_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .mode_flat(mode_flat), .lvl(lvl), .lvl_d(lvl_d),
    .clr(clr), .pend(pend)
  );

  gpc_groups #(.NPINS(NPINS), .NGRP(NGRP)) u_grp (
    .clk(clk), .rst(rst), .pend(pend), .grp_flat(grp_flat), .irq(grp_irq)
  );
endmodule

// File: rtl/gpc_checker.sv
module gpc_checker
  import gpc_pkg::*;
#(
  parameter int NPINS = 40,
  parameter int NGRP  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_cfg,
  input logic [31:0]        bus_rdata,
  input logic [NGRP-1:0]    grp_irq,
  input logic [NPINS-1:0]   pend,
  input logic [NPINS-1:0]   clr,
  input logic [NPINS-1:0]   lock_v,
  input logic [3*NPINS-1:0] mode_flat,
  input logic [3*NPINS-1:0] grp_flat
);
  logic [NGRP-1:0] hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_hit
    logic h;
    always_comb begin
      h = 1'b0;
      for (int p = 0; p < NPINS; p++)
        if (pend[p] && grp_flat[3*p +: 3] == 3'(g)) h = 1'b1;
    end
    assign hit[g] = h;

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (grp_irq[g] == $past(hit[g])));
  end

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_cfg && !rst) |-> ((bus_rdata & ~CFG_KEEP_MASK) == 32'h0));

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assert_quiet_no_event_R7: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && !pend[p] && (mode_flat[3*p +: 3] == 3'd7 || mode_flat[3*p +: 3] == 3'd1))
      |-> !pend[p]);

    assert_pending_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && pend[p] && !clr[p]) |-> pend[p]);

    assert_clear_takes_R9: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && clr[p]) |-> !pend[p]);

    assert_lock_holds_R11: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && lock_v[p]) |->
        (lock_v[p] && mode_flat[3*p +: 3] == $past(mode_flat[3*p +: 3])
                   && grp_flat[3*p +: 3] == $past(grp_flat[3*p +: 3])));
  end
endmodule

bind gpio_grp_ctrl gpc_checker #(.NPINS(NPINS), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst(rst),
  .rd_cfg(bus_rd && !bus_addr[ADDR_W-1]),
  .bus_rdata(bus_rdata), .grp_irq(grp_irq),
  .pend(pend), .clr(clr), .lock_v(lock_v),
  .mode_flat(mode_flat), .grp_flat(grp_flat)
);

// File: tb/sim_gpio_grp_ctrl.sv
module sim_gpio_grp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 40;
  localparam int NG = 8;
  localparam logic [31:0] KEEP = 32'h00E78FEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NG-1:0] grp_irq;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_grp_ctrl #(.NPINS(NP), .NGRP(NG), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pin_in = '0;
    waitc(3);
    rst = 1'b0;
  endtask

  function automatic logic [11:0] sa(input int g, input int pin);
    return 12'(12'h800 + 12'h40 * g + 4 * (pin / 32));
  endfunction

  function automatic logic [11:0] ca(input int pin);
    return 12'(4 * pin);
  endfunction

  task automatic chk_stat(input string req, input int g, input int pin, input logic exp);
    logic [31:0] v;
    rd(sa(g, pin), v);
    check(req, {31'b0, v[pin % 32]}, {31'b0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v, wd, e;
    int pins[5] = '{0, 5, 31, 32, 39};

    waitc(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {24'b0, grp_irq}, 32'h0);
    check("R1 oe", pin_oe[31:0], 32'h0);
    for (int p = 0; p < NP; p++) begin
      rd(ca(p), v);
      check("R1 cfg", v, 32'h0000000E);
    end
    // R2 beyond pin count
    rd(ca(NP), v);
    check("R2 beyond", v, 32'h0);

    // R2/R3 field mask sweep, lock bit kept clear
    for (int p = 0; p < NP; p++) begin
      wd = (32'(p) * 32'h9E3779B1 + 32'h5A5A00F3) & ~(32'h1 << 21);
      wr(ca(p), wd);
      rd(ca(p), v);
      e = wd & KEEP;
      if (e[3:1] != 3'd1) e[0] = 1'b0;
      check("R2 mask", v, e);
      check("R3 oe", {31'b0, pin_oe[p]}, {31'b0, (wd[3:1] == 3'd1)});
      if (wd[3:1] == 3'd1) check("R3 out", {31'b0, pin_out[p]}, {31'b0, wd[0]});
    end
    do_reset();

    // R3 output mode
    wr(ca(7), 32'h3);
    check("R3 oe7", {31'b0, pin_oe[7]}, 32'h1);
    check("R3 out7", {31'b0, pin_out[7]}, 32'h1);
    pin_in[7] = 1'b0;
    waitc(4);
    rd(ca(7), v);
    check("R3 read7", v, 32'h3);
    wr(ca(7), 32'h2);
    rd(ca(7), v);
    check("R3 read7b", v, 32'h2);
    check("R3 out7b", {31'b0, pin_out[7]}, 32'h0);
    wr(ca(7), 32'hE);

    // R4 live level readback, two patterns
    for (int pat = 0; pat < 2; pat++) begin
      @(negedge clk);
      pin_in = (pat == 0) ? 40'hA5_C3F0_0F96 : 40'h5A_3C0F_F069;
      waitc(3);
      for (int p = 0; p < NP; p++) begin
        rd(ca(p), v);
        check("R4 level", v, 32'hE | {31'b0, pin_in[p]});
      end
    end
    @(negedge clk);
    pin_in = '0;
    waitc(4);

    // R8/R10 group routing sweep, level-high source
    foreach (pins[j]) begin
      for (int g = 0; g < NG; g++) begin
        @(negedge clk);
        pin_in[pins[j]] = 1'b1;
        wr(ca(pins[j]), (32'(g) << 16) | 32'h4);
        waitc(5);
        check("R10 irq", {24'b0, grp_irq}, 32'h1 << g);
        for (int h = 0; h < NG; h++)
          chk_stat("R8 bank", h, pins[j], (h == g));
        wr(ca(pins[j]), (32'(g) << 16) | 32'hE);
        @(negedge clk);
        pin_in[pins[j]] = 1'b0;
        wr(sa(g, pins[j]), 32'h1 << (pins[j] % 32));
        waitc(2);
        check("R10 irq off", {24'b0, grp_irq}, 32'h0);
      end
    end

    // R5 level-high: re-assert after clear
    @(negedge clk);
    pin_in[10] = 1'b1;
    wr(ca(10), 32'h0001_0004);
    waitc(5);
    check("R5 irq", {24'b0, grp_irq}, 32'h2);
    wr(sa(1, 10), 32'h1 << 10);
    @(negedge clk);
    check("R5 gap", {24'b0, grp_irq}, 32'h0);
    @(negedge clk);
    check("R5 again", {24'b0, grp_irq}, 32'h2);
    pin_in[10] = 1'b0;
    waitc(5);
    chk_stat("R5 held", 1, 10, 1'b1);
    wr(sa(1, 10), 32'h1 << 10);
    waitc(2);
    chk_stat("R5 gone", 1, 10, 1'b0);
    wr(ca(10), 32'hE);
    // R5 level-low
    wr(ca(11), 32'h0001_0006);
    waitc(5);
    chk_stat("R5 low", 1, 11, 1'b1);
    pin_in[11] = 1'b1;
    waitc(5);
    wr(sa(1, 11), 32'h1 << 11);
    waitc(2);
    chk_stat("R5 low clr", 1, 11, 1'b0);
    wr(ca(11), 32'hE);
    @(negedge clk);
    pin_in[11] = 1'b0;

    // R6 rising, falling, both on pin 33 group 2
    wr(ca(33), 32'h0002_0008);
    waitc(4);
    chk_stat("R6 rise idle", 2, 33, 1'b0);
    @(negedge clk); pin_in[33] = 1'b1; waitc(5);
    chk_stat("R6 rise", 2, 33, 1'b1);
    @(negedge clk); pin_in[33] = 1'b0; waitc(5);
    chk_stat("R6 sticky", 2, 33, 1'b1);
    wr(sa(2, 33), 32'h2);
    waitc(2);
    chk_stat("R6 rise clr", 2, 33, 1'b0);
    wr(ca(33), 32'h0002_000A);
    @(negedge clk); pin_in[33] = 1'b1; waitc(5);
    chk_stat("R6 fall no", 2, 33, 1'b0);
    @(negedge clk); pin_in[33] = 1'b0; waitc(5);
    chk_stat("R6 fall", 2, 33, 1'b1);
    wr(sa(2, 33), 32'h2);
    wr(ca(33), 32'h0002_000C);
    @(negedge clk); pin_in[33] = 1'b1; waitc(5);
    chk_stat("R6 both up", 2, 33, 1'b1);
    wr(sa(2, 33), 32'h2);
    waitc(2);
    chk_stat("R6 both clr", 2, 33, 1'b0);
    @(negedge clk); pin_in[33] = 1'b0; waitc(5);
    chk_stat("R6 both dn", 2, 33, 1'b1);
    wr(sa(2, 33), 32'h2);
    waitc(2);
    chk_stat("R6 end", 2, 33, 1'b0);
    wr(ca(33), 32'hE);

    // R7 mode 7 and output mode raise nothing
    @(negedge clk); pin_in[12] = 1'b1; waitc(5);
    @(negedge clk); pin_in[12] = 1'b0; waitc(5);
    chk_stat("R7 quiet", 0, 12, 1'b0);
    wr(ca(12), 32'h2);
    @(negedge clk); pin_in[12] = 1'b1; waitc(5);
    @(negedge clk); pin_in[12] = 1'b0; waitc(5);
    chk_stat("R7 out", 0, 12, 1'b0);
    check("R7 irq", {24'b0, grp_irq}, 32'h0);
    wr(ca(12), 32'hE);

    // R9 write-zero and wrong-bank writes do nothing
    wr(ca(13), 32'h0003_0008);
    @(negedge clk); pin_in[13] = 1'b1; waitc(5);
    chk_stat("R9 set", 3, 13, 1'b1);
    wr(sa(3, 13), 32'h0);
    chk_stat("R9 zero", 3, 13, 1'b1);
    wr(sa(4, 13), 32'h1 << 13);
    chk_stat("R9 other bank", 3, 13, 1'b1);
    check("R9 irq", {24'b0, grp_irq}, 32'h8);
    wr(sa(3, 13), 32'h1 << 13);
    waitc(2);
    chk_stat("R9 clr", 3, 13, 1'b0);
    wr(ca(13), 32'hE);
    @(negedge clk); pin_in[13] = 1'b0;

    // R11 lock
    wr(ca(3), 32'h0020_0002);
    wr(ca(3), 32'h0005_0001);
    rd(ca(3), v);
    check("R11 data only", v, 32'h0020_0003);
    check("R11 out", {31'b0, pin_out[3]}, 32'h1);
    wr(ca(3), 32'h0);
    rd(ca(3), v);
    check("R11 still", v, 32'h0020_0002);

    // R12 mode change keeps pending
    wr(ca(14), 32'h8);
    @(negedge clk); pin_in[14] = 1'b1; waitc(5);
    chk_stat("R12 set", 0, 14, 1'b1);
    wr(ca(14), 32'hE);
    waitc(3);
    chk_stat("R12 kept", 0, 14, 1'b1);
    wr(ca(14), 32'h6);
    waitc(3);
    chk_stat("R12 kept2", 0, 14, 1'b1);
    wr(ca(14), 32'hE);
    wr(sa(0, 14), 32'h1 << 14);
    waitc(2);
    chk_stat("R12 clr", 0, 14, 1'b0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule